// File: doc/BRIEF.md
# UART Receive Data Queue

This block is the receive-side store of a memory-mapped serial port. A deserializer, or a transmit-to-receive loopback path, hands it received words. Each word is 12 bits: the character sits in bits 7:0, and four per-character error flags sit in bits 11:8. Bit 8 is framing, bit 9 is parity, bit 10 is break and bit 11 is overrun. The words are held in a circular buffer. A read strobe on the data register removes the oldest word, and the same strobe copies that word's error field into a receive status register.

The buffer runs in one of two modes, and a control bit written through the line-control register selects the mode. With the bit set, the queue holds 16 words. With the bit clear, it acts as a single holding register. Any change of that bit throws away the queue contents. The block reports empty, full and ready-to-accept status. It raises a receive interrupt request when the occupancy climbs to the trigger level of one word, and drops it when a read takes the occupancy back below that level. When the queue is disabled, a line-break event places a break word in the holding register. The block also holds the reset value of the level-select register.

Top module: `uart_rxq`

## Requirements
- R1: With the mode bit set (`cfg_fifo_en`=1 captured by `cfg_wr`), the effective depth is 16. With it clear, the effective depth is 1. After reset the mode is clear.
- R2: An accepted push appends `push_word` at the tail of the queue and raises the occupancy by one. `full` is 1 exactly when the occupancy equals the effective depth. A push that finds no room is discarded and leaves the contents unchanged.
- R3: `empty` is 1 exactly when the occupancy is zero.
- R4: `pop_word` always shows the oldest stored word. A `pop` removes that word only when the queue is not empty, so words leave in arrival order across pointer wrap-around. A `pop` on an empty queue changes no contents.
- R5: `can_accept` is 1 exactly when the occupancy is below the effective depth.
- R6: `rx_irq` rises in the cycle after a push brings the occupancy to 1. It falls after any `pop` that leaves the occupancy at 0, including a pop of an empty queue. It does not change otherwise.
- R7: When `pop` and a push occur in the same cycle, the read is applied first. A full queue therefore accepts the push, and stays full with its head advanced.
- R8: `stat_wr` clears all four bits of `stat_err`. A `pop` loads `stat_err` with bits 11:8 of the word at the head. `stat_wr` wins over the other updates made in the same cycle.
- R9: A `cfg_wr` that changes the mode bit empties the queue. In that cycle, pop, push and break have no effect, and `rx_irq` keeps its value. A `cfg_wr` that leaves the mode unchanged has no effect.
- R10: A `brk_evt` while the mode bit is clear pushes the word 0x400 in place of any `push_word`, and sets `stat_err[2]`. While the mode bit is set, `brk_evt` is ignored.
- R11: `lvl_sel` resets to 0x12 and loads `lvl_wdata` on `lvl_wr`. It does not change the interrupt trigger.
- R12: After reset the queue is empty, `full` and `rx_irq` are 0, `can_accept` is 1 and `stat_err` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| push_vld | input | 1 | A received word is offered this cycle |
| push_word | input | 12 | Received word: character in 7:0, error flags in 11:8 |
| brk_evt | input | 1 | Line-break event |
| pop | input | 1 | Data-register read strobe |
| pop_word | output | 12 | Oldest stored word |
| cfg_wr | input | 1 | Line-control write strobe |
| cfg_fifo_en | input | 1 | Mode bit carried by the line-control write |
| stat_wr | input | 1 | Receive status register write (clears it) |
| stat_err | output | 4 | Receive status register error bits |
| lvl_wr | input | 1 | Level-select register write strobe |
| lvl_wdata | input | 6 | Level-select write data |
| lvl_sel | output | 6 | Level-select register |
| empty | output | 1 | Queue empty |
| full | output | 1 | Queue holds its effective depth |
| can_accept | output | 1 | Room for one more word |
| rx_irq | output | 1 | Raw receive interrupt request |

## Verification
The queue is first driven in holding-register mode with single pushes, pushes that find it full, and break events. These patterns separate the depth-1 masking from the 16-deep behaviour and show that a break lands in the data path. In queue mode, a full fill followed by a drain, and a partial fill that wraps the read pointer, expose pointer and occupancy errors. Simultaneous read and push on a full queue checks the read-first order. Mode changes made with data present separate a flush from a silent reconfiguration, and check that the interrupt survives the flush until a read of the empty queue. A long pseudo-random mix of all inputs is compared cycle by cycle against a queue-based model.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam int DATA_W  = 8;
  localparam int ERR_W   = 4;
  localparam int WORD_W  = DATA_W + ERR_W;
  localparam int BRK_IDX = 2;
  localparam logic [WORD_W-1:0] BRK_WORD = WORD_W'(1) << (DATA_W + BRK_IDX);
  typedef logic [WORD_W-1:0] rx_word_t;
  typedef logic [ERR_W-1:0]  rx_err_t;
endpackage

// File: rtl/rxq_mem.sv
module rxq_mem
  import rxq_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [PTR_W-1:0] wr_ptr,
  input  rx_word_t         wr_word,
  input  logic [PTR_W-1:0] rd_ptr,
  output rx_word_t         rd_word
);

  rx_word_t slot_w [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    rx_word_t slot_q;
    logic     slot_en;

    assign slot_en = wr_en && (wr_ptr == PTR_W'(g));

    always_ff @(posedge clk) begin
      if (slot_en) begin
        slot_q <= wr_word;
      end
    end

    assign slot_w[g] = slot_q;
  end

  assign rd_word = slot_w[rd_ptr];

endmodule

// File: rtl/rxq_ctrl.sv
module rxq_ctrl #(
  parameter int DEPTH = 16,
  parameter int TRIG  = 1,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = PTR_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic             cfg_fifo_en,
  input  logic             pop,
  input  logic             push_vld,
  input  logic             brk_evt,
  output logic             mode_q,
  output logic             pop_ok,
  output logic             brk_ok,
  output logic             wr_en,
  output logic [PTR_W-1:0] wr_ptr,
  output logic [PTR_W-1:0] rd_ptr,
  output logic [CNT_W-1:0] cnt_q,
  output logic             irq_q,
  output logic             empty,
  output logic             full,
  output logic             can_accept
);

  logic             flush;
  logic             push_req;
  logic             take;
  logic [CNT_W-1:0] cnt_lim;
  logic [PTR_W-1:0] ptr_mask;
  logic [CNT_W-1:0] cnt_a;
  logic [CNT_W-1:0] cnt_b;
  logic [CNT_W-1:0] cnt_n;
  logic [PTR_W-1:0] rd_n;
  logic             irq_n;
  logic             ptr_en;
  logic             irq_en;

  // next-state logic: the read is applied before the push
  always_comb begin
    flush    = cfg_wr && (cfg_fifo_en != mode_q);
    pop_ok   = pop && !flush;
    brk_ok   = brk_evt && !mode_q && !flush;
    push_req = (push_vld && !flush) || brk_ok;
    cnt_lim  = mode_q ? CNT_W'(DEPTH) : CNT_W'(1);
    ptr_mask = mode_q ? PTR_W'(DEPTH - 1) : '0;
    take     = pop_ok && (cnt_q != '0);
    cnt_a    = take ? (cnt_q - CNT_W'(1)) : cnt_q;
    wr_en    = push_req && (cnt_a < cnt_lim);
    cnt_b    = wr_en ? (cnt_a + CNT_W'(1)) : cnt_a;
    wr_ptr   = (rd_ptr + cnt_q[PTR_W-1:0]) & ptr_mask;
    rd_n     = flush ? '0 : (take ? ((rd_ptr + PTR_W'(1)) & ptr_mask) : rd_ptr);
    cnt_n    = flush ? '0 : cnt_b;
    irq_n    = irq_q;
    if (pop_ok && (cnt_a == CNT_W'(TRIG - 1))) begin
      irq_n = 1'b0;
    end
    if (wr_en && (cnt_b == CNT_W'(TRIG))) begin
      irq_n = 1'b1;
    end
    ptr_en = flush || take || wr_en;
    irq_en = pop_ok || wr_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      rd_ptr <= '0;
    end else if (ptr_en) begin
      cnt_q  <= cnt_n;
      rd_ptr <= rd_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 1'b0;
    end else if (cfg_wr) begin
      mode_q <= cfg_fifo_en;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
    end else if (irq_en) begin
      irq_q <= irq_n;
    end
  end

  assign empty      = (cnt_q == '0);
  assign full       = (cnt_q == cnt_lim);
  assign can_accept = (cnt_q < cnt_lim);

endmodule

// File: rtl/rxq_stat.sv
module rxq_stat
  import rxq_pkg::*;
#(
  parameter int LVL_W = 6,
  parameter logic [LVL_W-1:0] LVL_RST = 6'h12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pop_ok,
  input  rx_err_t          head_err,
  input  logic             brk_ok,
  input  logic             stat_wr,
  input  logic             lvl_wr,
  input  logic [LVL_W-1:0] lvl_wdata,
  output rx_err_t          stat_q,
  output logic [LVL_W-1:0] lvl_q
);

  rx_err_t stat_n;
  logic    stat_en;

  always_comb begin
    stat_n = stat_q;
    if (pop_ok) begin
      stat_n = head_err;
    end
    if (brk_ok) begin
      stat_n[BRK_IDX] = 1'b1;
    end
    if (stat_wr) begin
      stat_n = '0;
    end
    stat_en = pop_ok || brk_ok || stat_wr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
    end else if (stat_en) begin
      stat_q <= stat_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= LVL_RST;
    end else if (lvl_wr) begin
      lvl_q <= lvl_wdata;
    end
  end

endmodule

// File: rtl/uart_rxq.sv
module uart_rxq
  import rxq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int TRIG  = 1,
  parameter int LVL_W = 6,
  parameter logic [LVL_W-1:0] LVL_RST = 6'h12,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = PTR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_vld,
  input  logic [WORD_W-1:0] push_word,
  input  logic              brk_evt,
  input  logic              pop,
  output logic [WORD_W-1:0] pop_word,
  input  logic              cfg_wr,
  input  logic              cfg_fifo_en,
  input  logic              stat_wr,
  output logic [ERR_W-1:0]  stat_err,
  input  logic              lvl_wr,
  input  logic [LVL_W-1:0]  lvl_wdata,
  output logic [LVL_W-1:0]  lvl_sel,
  output logic              empty,
  output logic              full,
  output logic              can_accept,
  output logic              rx_irq
);

  logic             mode_q;
  logic             pop_ok;
  logic             brk_ok;
  logic             wr_en;
  logic [PTR_W-1:0] wr_ptr;
  logic [PTR_W-1:0] rd_ptr;
  logic [CNT_W-1:0] cnt_q;
  rx_word_t         wr_word;
  rx_word_t         head_word;

  rxq_ctrl #(.DEPTH(DEPTH), .TRIG(TRIG)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_wr     (cfg_wr),
    .cfg_fifo_en(cfg_fifo_en),
    .pop        (pop),
    .push_vld   (push_vld),
    .brk_evt    (brk_evt),
    .mode_q     (mode_q),
    .pop_ok     (pop_ok),
    .brk_ok     (brk_ok),
    .wr_en      (wr_en),
    .wr_ptr     (wr_ptr),
    .rd_ptr     (rd_ptr),
    .cnt_q      (cnt_q),
    .irq_q      (rx_irq),
    .empty      (empty),
    .full       (full),
    .can_accept (can_accept)
  );

  // a break word takes the push slot
  assign wr_word = brk_ok ? BRK_WORD : push_word;

  rxq_mem #(.DEPTH(DEPTH)) u_mem (
    .clk    (clk),
    .wr_en  (wr_en),
    .wr_ptr (wr_ptr),
    .wr_word(wr_word),
    .rd_ptr (rd_ptr),
    .rd_word(head_word)
  );

  rxq_stat #(.LVL_W(LVL_W), .LVL_RST(LVL_RST)) u_stat (
    .clk      (clk),
    .rst_n    (rst_n),
    .pop_ok   (pop_ok),
    .head_err (head_word[WORD_W-1:DATA_W]),
    .brk_ok   (brk_ok),
    .stat_wr  (stat_wr),
    .lvl_wr   (lvl_wr),
    .lvl_wdata(lvl_wdata),
    .stat_q   (stat_err),
    .lvl_q    (lvl_sel)
  );

  assign pop_word = head_word;

endmodule

// File: rtl/uart_rxq_chk.sv
module uart_rxq_chk #(
  parameter int CNT_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             push_vld,
  input logic             brk_evt,
  input logic             pop,
  input logic             cfg_wr,
  input logic             cfg_fifo_en,
  input logic             stat_wr,
  input logic [3:0]       stat_err,
  input logic             empty,
  input logic             full,
  input logic             can_accept,
  input logic             rx_irq,
  input logic             mode_q,
  input logic [CNT_W-1:0] cnt_q
);

  // R2: a push into a full queue without a read leaves the occupancy alone
  a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (full && (push_vld || brk_evt) && !pop && !cfg_wr) |=> $stable(cnt_q));

  // R4: reading an empty queue with nothing arriving keeps it empty
  a_r4_pop_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && pop && !push_vld && !brk_evt && !cfg_wr) |=> empty);

  // R5: a full queue never offers room
  a_r5_no_room_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !can_accept);

  // R6: first arrival raises the request
  a_r6_irq_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && push_vld && !cfg_wr) |=> (rx_irq && !empty));

  // R6: only a read can drop the request
  a_r6_irq_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_irq && !pop) |=> rx_irq);

  // R8: status write clears every error bit
  a_r8_stat_clear: assert property (@(posedge clk) disable iff (!rst_n)
    stat_wr |=> (stat_err == 4'h0));

  // R9: a mode change empties the queue
  a_r9_flush: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && (cfg_fifo_en != mode_q)) |=> empty);

endmodule

bind uart_rxq uart_rxq_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .push_vld   (push_vld),
  .brk_evt    (brk_evt),
  .pop        (pop),
  .cfg_wr     (cfg_wr),
  .cfg_fifo_en(cfg_fifo_en),
  .stat_wr    (stat_wr),
  .stat_err   (stat_err),
  .empty      (empty),
  .full       (full),
  .can_accept (can_accept),
  .rx_irq     (rx_irq),
  .mode_q     (mode_q),
  .cnt_q      (cnt_q)
);

// File: tb/uart_rxq_bench.sv
module uart_rxq_bench;

  logic        clk;
  logic        rst_n;
  logic        push_vld;
  logic [11:0] push_word;
  logic        brk_evt;
  logic        pop;
  logic [11:0] pop_word;
  logic        cfg_wr;
  logic        cfg_fifo_en;
  logic        stat_wr;
  logic [3:0]  stat_err;
  logic        lvl_wr;
  logic [5:0]  lvl_wdata;
  logic [5:0]  lvl_sel;
  logic        empty;
  logic        full;
  logic        can_accept;
  logic        rx_irq;

  int n_chk;
  int n_fail;

  uart_rxq u_uart_rxq (
    .clk        (clk),
    .rst_n      (rst_n),
    .push_vld   (push_vld),
    .push_word  (push_word),
    .brk_evt    (brk_evt),
    .pop        (pop),
    .pop_word   (pop_word),
    .cfg_wr     (cfg_wr),
    .cfg_fifo_en(cfg_fifo_en),
    .stat_wr    (stat_wr),
    .stat_err   (stat_err),
    .lvl_wr     (lvl_wr),
    .lvl_wdata  (lvl_wdata),
    .lvl_sel    (lvl_sel),
    .empty      (empty),
    .full       (full),
    .can_accept (can_accept),
    .rx_irq     (rx_irq)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // ---------------- reference model ----------------
  logic [11:0] m_q [$];
  bit          m_mode;
  bit          m_irq;
  logic [3:0]  m_stat;
  bit          m_stat_ok;
  logic [5:0]  m_lvl;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_q.delete();
      m_mode    = 1'b0;
      m_irq     = 1'b0;
      m_stat    = 4'h0;
      m_stat_ok = 1'b1;
      m_lvl     = 6'h12;
    end else begin
      bit          fl;
      bit          bk;
      int          dep;
      logic [11:0] w;
      fl = cfg_wr && (cfg_fifo_en != m_mode);
      if (fl) begin
        m_q.delete();
        m_mode = cfg_fifo_en;
      end else begin
        if (cfg_wr) m_mode = cfg_fifo_en;
        dep = m_mode ? 16 : 1;
        if (pop) begin
          if (m_q.size() > 0) begin
            w = m_q.pop_front();
            m_stat = w[11:8];
          end else begin
            m_stat_ok = 1'b0;
          end
          if (m_q.size() == 0) m_irq = 1'b0;
        end
        bk = brk_evt && !m_mode;
        if ((bk || push_vld) && (m_q.size() < dep)) begin
          m_q.push_back(bk ? 12'h400 : push_word);
          if (m_q.size() == 1) m_irq = 1'b1;
        end
        if (bk) m_stat[2] = 1'b1;
      end
      if (stat_wr) begin
        m_stat    = 4'h0;
        m_stat_ok = 1'b1;
      end
      if (lvl_wr) m_lvl = lvl_wdata;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      int dep;
      dep = m_mode ? 16 : 1;
      chk(empty == (m_q.size() == 0), "R3 empty", empty, m_q.size() == 0);
      chk(full == (m_q.size() == dep), "R1 R2 full", full, m_q.size() == dep);
      chk(can_accept == (m_q.size() < dep), "R5 can_accept", can_accept, m_q.size() < dep);
      chk(rx_irq == m_irq, "R6 rx_irq", rx_irq, m_irq);
      chk(lvl_sel == m_lvl, "R11 lvl_sel", lvl_sel, m_lvl);
      if (m_q.size() > 0)
        chk(pop_word == m_q[0], "R4 pop_word", pop_word, m_q[0]);
      if (m_stat_ok)
        chk(stat_err == m_stat, "R8 stat_err", stat_err, m_stat);
    end
  end

  // ---------------- stimulus ----------------
  task automatic idle();
    push_vld = 0; push_word = '0; brk_evt = 0; pop = 0;
    cfg_wr = 0; stat_wr = 0; lvl_wr = 0; lvl_wdata = '0;
  endtask

  task automatic cyc(input bit p_push, input logic [11:0] p_w, input bit p_pop,
                     input bit p_brk, input bit p_cfg, input bit p_en,
                     input bit p_swr, input bit p_lwr, input logic [5:0] p_lv);
    @(negedge clk);
    #1;
    push_vld = p_push; push_word = p_w; pop = p_pop; brk_evt = p_brk;
    cfg_wr = p_cfg; cfg_fifo_en = p_en; stat_wr = p_swr;
    lvl_wr = p_lwr; lvl_wdata = p_lv;
    @(posedge clk);
    #1;
    idle();
  endtask

  task automatic push1(input logic [11:0] w);
    cyc(1, w, 0, 0, 0, cfg_fifo_en, 0, 0, '0);
  endtask

  task automatic pop1();
    cyc(0, '0, 1, 0, 0, cfg_fifo_en, 0, 0, '0);
  endtask

  task automatic set_mode(input bit en);
    cyc(0, '0, 0, 0, 1, en, 0, 0, '0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] lf;
    n_chk = 0; n_fail = 0;
    idle();
    cfg_fifo_en = 0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    #2;
    // R12 reset state
    chk(empty == 1 && full == 0 && can_accept == 1, "R12 flags after reset", {empty, full, can_accept}, 3'b101);
    chk(rx_irq == 0 && stat_err == 0, "R12 irq/status after reset", {rx_irq, stat_err}, 0);
    chk(lvl_sel == 6'h12, "R11 level reset", lvl_sel, 6'h12);

    // holding-register mode: R1 depth 1, R2 discard
    push1(12'h1A5);
    #1 chk(full == 1 && rx_irq == 1, "R1 one word fills", {full, rx_irq}, 2'b11);
    push1(12'h0C3);
    #1 chk(pop_word == 12'h1A5, "R2 push while full discarded", pop_word, 12'h1A5);
    pop1();
    #1 chk(empty == 1 && rx_irq == 0 && stat_err == 4'h1, "R8 pop loads status", {empty, rx_irq, stat_err}, 6'b100001);

    // R10 break in holding mode
    cyc(1, 12'h055, 0, 1, 0, 0, 0, 0, '0);
    #1 chk(pop_word == 12'h400 && stat_err[2] == 1, "R10 break word stored", pop_word, 12'h400);
    cyc(0, '0, 0, 0, 0, 0, 1, 0, '0);
    #1 chk(stat_err == 0, "R8 status write clears", stat_err, 0);
    pop1();

    // R9 flush on enable, R1 16-deep, R7 read-first
    set_mode(1);
    for (int i = 0; i < 17; i++) push1(12'((i * 37 + 5) & 12'hFFF));
    #1 chk(full == 1, "R1 sixteen words fill", full, 1);
    cyc(1, 12'hABC, 1, 0, 0, 1, 0, 0, '0);
    #1 chk(full == 1 && pop_word == 12'((37 + 5) & 12'hFFF), "R7 read then push on full", pop_word, (37 + 5));
    for (int i = 0; i < 16; i++) pop1();
    #1 chk(empty == 1 && rx_irq == 0, "R4 drained in order", {empty, rx_irq}, 2'b10);

    // R10 break ignored in queue mode
    cyc(0, '0, 0, 1, 0, 1, 0, 0, '0);
    #1 chk(empty == 1, "R10 break ignored when queue on", empty, 1);

    // wrap-around
    for (int k = 0; k < 3; k++) begin
      for (int i = 0; i < 11; i++) push1(12'(k * 64 + i));
      for (int i = 0; i < 9; i++) pop1();
    end
    // R9 same mode write does nothing, changing mode flushes but keeps irq
    set_mode(1);
    #1 chk(empty == 0, "R9 unchanged mode keeps data", empty, 0);
    set_mode(0);
    #1 chk(empty == 1 && rx_irq == 1, "R9 flush keeps irq", {empty, rx_irq}, 2'b11);
    pop1();
    #1 chk(rx_irq == 0, "R6 pop of empty clears irq", rx_irq, 0);
    cyc(0, '0, 0, 0, 0, 0, 1, 0, '0);

    // R11 level register
    cyc(0, '0, 0, 0, 0, 0, 0, 1, 6'h2D);
    #1 chk(lvl_sel == 6'h2D, "R11 level write", lvl_sel, 6'h2D);

    // pseudo-random mix
    lf = 16'hACE1;
    for (int i = 0; i < 4000; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      cyc(lf[0], {lf[11:8], lf[15:8]}, lf[1] & (lf[2] | lf[3]),
          (lf[6:2] == 5'd7), (lf[9:4] == 6'd11), lf[12],
          (lf[7:4] == 4'd3), (lf[10:6] == 5'd9), lf[5:0]);
    end
    repeat (2) @(posedge clk);
    @(negedge clk);
    #1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule